// File: doc/BRIEF.md
# Codec Interrupt Flag and Mask Unit

This unit gathers six single-cycle event strobes from an audio codec (jack change, output short-circuit, headphone ramp-up finished, headphone ramp-down finished, digital gain-up finished, digital gain-down finished) and latches each one in a sticky flag register. Software reads the flags, and clears any of them by writing ones to those bit positions. A second byte-wide register holds one mask bit per source and a two-bit field that chooses how the interrupt line behaves.

The interrupt line is formed from the flags whose mask bit is clear. It can be an active-high level, an active-low level, or a one-cycle pulse each time an unmasked flag goes from clear to set. The flag register also carries the live state of the jack-present input in a separate, unlatched bit. The register bridge reads a nine-bit word: the selected register in the low byte and the current interrupt line in the top bit.

Top module: `codec_irq_unit`

## Requirements
- R1: After synchronous reset the control register reads 0x3F, the latched flags read 0x00, and the interrupt line is low.
- R2: The control register stores all eight written bits and reads them back unchanged. Bits 5:0 are masks: bit 5 jack change, bit 4 short-circuit, bit 3 ramp-up done, bit 2 ramp-down done, bit 1 gain-up done, bit 0 gain-down done. Bits 7:6 are the output form.
- R3: A high on event input bit i sets flag bit i (same bit order as the masks) at the next clock edge. The flag stays set after the strobe ends, whatever the state of the mask.
- R4: A flag write clears each flag in bits 5:0 where the written bit is 1 and leaves the flag alone where it is 0. Written bits 7:6 have no effect, and writing 0x3F clears every latched flag.
- R5: When an event and a clearing write hit the same flag bit in the same cycle, the flag ends up set.
- R6: Flag register bit 6 shows the present level of the jack-present input with no latching. Bit 7 always reads 0.
- R7: A mask bit of 1 removes its flag from the interrupt. The line is driven from the OR of the flags in bits 5:0 whose mask bit is 0.
- R8: Form 00 drives the line high while any unmasked flag is set. Form 01 drives it low in that case and high otherwise.
- R9: Forms 10 and 11 drive the line high for exactly one cycle, in the cycle after an unmasked flag goes from 0 to 1. There is no pulse when the flag was already set, when it is masked, or when only the mask or form changes.
- R10: The read word holds the control register in bits 7:0 when the read select is 0, and the flag register when it is 1. Bit 8 always equals the interrupt line.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| ctl_wr_en | input | 1 | Write strobe for the control register |
| ctl_wr_data | input | 8 | Control register write value |
| flag_wr_en | input | 1 | Write strobe for the flag register (write-one-to-clear) |
| flag_wr_data | input | 8 | Flag clear pattern |
| evt_pulse | input | 6 | Event strobes, one per source |
| jack_present | input | 1 | Live jack-present level |
| rd_sel | input | 1 | Read select: 0 control, 1 flags |
| rd_word | output | 9 | Read data: interrupt line in bit 8, selected register in 7:0 |
| irq_out | output | 1 | Interrupt line |

## Verification
The bench latches a fixed flag pattern, then sweeps all 64 mask values under both level forms and checks the line against the OR of the unmasked flags. A design with a mask polarity or bit order wrong would fail many of these points. The clear path is tested with patterns of zeros and with upper-bit-only writes, so a design that cleared on zero or honoured bits 7:6 would lose flags. An event that lands on the same bit as a clearing write must leave the flag set; a design that let the clear win would drop that event. In pulse form the bench checks that a pulse lasts one cycle only, and that no pulse comes from a flag already set, from a masked flag, or from a mask write. A design that treated pulse form as a level, or fired on the mask change, would fail those checks.

// File: rtl/codec_irq_pkg.sv
package codec_irq_pkg;

    localparam int NUM_SRC       = 6;
    localparam int REG_W         = 8;
    localparam int FORM_W        = REG_W - NUM_SRC;
    localparam int JACK_LIVE_BIT = NUM_SRC;
    localparam int RD_W          = REG_W + 1;

    typedef enum logic [FORM_W-1:0] {
        FORM_HIGH      = 2'b00,
        FORM_LOW       = 2'b01,
        FORM_PULSE     = 2'b10,
        FORM_PULSE_ALT = 2'b11
    } irq_form_e;

    typedef struct packed {
        irq_form_e          form;
        logic [NUM_SRC-1:0] mask;
    } irq_ctl_t;

    localparam irq_ctl_t CTL_RESET = '{form: FORM_HIGH, mask: '1};

    function automatic logic form_is_pulse(irq_form_e f);
        return f[FORM_W-1];
    endfunction

    function automatic logic [REG_W-1:0] pack_flags(logic [NUM_SRC-1:0] latched,
                                                    logic jack_level);
        logic [REG_W-1:0] w;
        w = '0;
        w[NUM_SRC-1:0]   = latched;
        w[JACK_LIVE_BIT] = jack_level;
        return w;
    endfunction

endpackage

// File: rtl/codec_irq_ctl_reg.sv
module codec_irq_ctl_reg
    import codec_irq_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  logic             wr_en,
    input  logic [REG_W-1:0] wr_data,
    output irq_ctl_t         ctl
);

    always_ff @(posedge clk) begin
        if (rst) begin
            ctl <= CTL_RESET;
        end else if (wr_en) begin
            ctl <= irq_ctl_t'(wr_data);
        end
    end

    // Control only moves on a write (R2)
    assert_ctl_hold_R2: assert property (@(posedge clk) disable iff (rst)
        !wr_en |=> $stable(ctl));

    // A write lands exactly the written byte (R2)
    assert_ctl_write_R2: assert property (@(posedge clk) disable iff (rst)
        wr_en |=> (ctl == $past(wr_data)));

endmodule

// File: rtl/codec_irq_flag_bank.sv
module codec_irq_flag_bank
    import codec_irq_pkg::*;
(
    input  logic               clk,
    input  logic               rst,
    input  logic [NUM_SRC-1:0] evt,
    input  logic               clr_en,
    input  logic [NUM_SRC-1:0] clr_bits,
    output logic [NUM_SRC-1:0] flags
);

    for (genvar i = 0; i < NUM_SRC; i++) begin : g_flag
        always_ff @(posedge clk) begin
            if (rst) begin
                flags[i] <= 1'b0;
            end else if (evt[i]) begin
                flags[i] <= 1'b1;
            end else if (clr_en && clr_bits[i]) begin
                flags[i] <= 1'b0;
            end
        end

        // Event sets the flag, even against a clear (R3, R5)
        assert_evt_sets_R3: assert property (@(posedge clk) disable iff (rst)
            evt[i] |=> flags[i]);

        assert_evt_beats_clear_R5: assert property (@(posedge clk) disable iff (rst)
            (evt[i] && clr_en && clr_bits[i]) |=> flags[i]);

        // Clear without event drops the flag (R4)
        assert_w1c_clears_R4: assert property (@(posedge clk) disable iff (rst)
            (!evt[i] && clr_en && clr_bits[i]) |=> !flags[i]);

        // No event, no clear: flag holds (R3)
        assert_flag_sticky_R3: assert property (@(posedge clk) disable iff (rst)
            (!evt[i] && !(clr_en && clr_bits[i])) |=> $stable(flags[i]));
    end

endmodule

// File: rtl/codec_irq_out.sv
module codec_irq_out
    import codec_irq_pkg::*;
(
    input  logic               clk,
    input  logic               rst,
    input  irq_ctl_t           ctl,
    input  logic [NUM_SRC-1:0] flags,
    output logic               irq
);

    logic [NUM_SRC-1:0] flags_prev;
    logic [NUM_SRC-1:0] armed;
    logic [NUM_SRC-1:0] newly_set;
    logic               any_armed;

    always_ff @(posedge clk) begin
        if (rst) begin
            flags_prev <= '0;
        end else begin
            flags_prev <= flags;
        end
    end

    always_comb begin
        armed     = flags & ~ctl.mask;
        newly_set = armed & ~flags_prev;
        any_armed = |armed;
        if (form_is_pulse(ctl.form)) begin
            irq = |newly_set;
        end else if (ctl.form == FORM_LOW) begin
            irq = ~any_armed;
        end else begin
            irq = any_armed;
        end
    end

    // Fully masked: line sits at its idle level (R7)
    assert_all_masked_idle_R7: assert property (@(posedge clk) disable iff (rst)
        (&ctl.mask) |-> (irq == (ctl.form == FORM_LOW)));

    // Active-low form idles high when no flag is latched (R8)
    assert_low_form_idle_R8: assert property (@(posedge clk) disable iff (rst)
        (ctl.form == FORM_LOW && flags == '0) |-> irq);

    // Pulse form: unchanged flags produce no pulse (R9)
    assert_pulse_needs_edge_R9: assert property (@(posedge clk) disable iff (rst)
        (form_is_pulse(ctl.form) && flags == $past(flags)) |-> !irq);

endmodule

// File: rtl/codec_irq_unit.sv
module codec_irq_unit
    import codec_irq_pkg::*;
(
    input  logic               clk,
    input  logic               rst,
    input  logic               ctl_wr_en,
    input  logic [REG_W-1:0]   ctl_wr_data,
    input  logic               flag_wr_en,
    input  logic [REG_W-1:0]   flag_wr_data,
    input  logic [NUM_SRC-1:0] evt_pulse,
    input  logic               jack_present,
    input  logic               rd_sel,
    output logic [RD_W-1:0]    rd_word,
    output logic               irq_out
);

    irq_ctl_t           ctl;
    logic [NUM_SRC-1:0] flags;
    logic [REG_W-1:0]   flag_view;
    logic               unused_clr_hi;

    assign unused_clr_hi = ^flag_wr_data[REG_W-1:NUM_SRC];

    codec_irq_ctl_reg u_ctl (
        .clk     (clk),
        .rst     (rst),
        .wr_en   (ctl_wr_en),
        .wr_data (ctl_wr_data),
        .ctl     (ctl)
    );

    codec_irq_flag_bank u_flags (
        .clk      (clk),
        .rst      (rst),
        .evt      (evt_pulse),
        .clr_en   (flag_wr_en),
        .clr_bits (flag_wr_data[NUM_SRC-1:0]),
        .flags    (flags)
    );

    codec_irq_out u_out (
        .clk   (clk),
        .rst   (rst),
        .ctl   (ctl),
        .flags (flags),
        .irq   (irq_out)
    );

    always_comb begin
        flag_view = pack_flags(flags, jack_present);
        rd_word   = {irq_out, (rd_sel ? flag_view : REG_W'(ctl))};
    end

    // Jack bit is live, top bit is zero (R6)
    assert_jack_live_R6: assert property (@(posedge clk) disable iff (rst)
        rd_sel |-> (rd_word[JACK_LIVE_BIT] == jack_present && rd_word[REG_W-1] == 1'b0));

endmodule

// File: tb/codec_irq_unit_tb.sv
module codec_irq_unit_tb;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       ctl_wr_en = 1'b0;
    logic [7:0] ctl_wr_data = '0;
    logic       flag_wr_en = 1'b0;
    logic [7:0] flag_wr_data = '0;
    logic [5:0] evt_pulse = '0;
    logic       jack_present = 1'b0;
    logic       rd_sel = 1'b0;
    logic [8:0] rd_word;
    logic       irq_out;

    int errors = 0;
    int checks = 0;
    bit done = 1'b0;

    always #10 clk = ~clk;

    codec_irq_unit u_dut (
        .clk(clk), .rst(rst),
        .ctl_wr_en(ctl_wr_en), .ctl_wr_data(ctl_wr_data),
        .flag_wr_en(flag_wr_en), .flag_wr_data(flag_wr_data),
        .evt_pulse(evt_pulse), .jack_present(jack_present),
        .rd_sel(rd_sel), .rd_word(rd_word), .irq_out(irq_out)
    );

    task automatic chk(input string tag, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s: actual=0x%0h expected=0x%0h", tag, act, exp);
        end
    endtask

    task automatic rd(input bit sel, output logic [8:0] w);
        rd_sel = sel;
        #1;
        w = rd_word;
    endtask

    task automatic wr_ctl(input logic [7:0] v);
        ctl_wr_en = 1'b1; ctl_wr_data = v;
        @(negedge clk);
        ctl_wr_en = 1'b0;
    endtask

    task automatic clr(input logic [7:0] v);
        flag_wr_en = 1'b1; flag_wr_data = v;
        @(negedge clk);
        flag_wr_en = 1'b0;
    endtask

    task automatic fire(input logic [5:0] v);
        evt_pulse = v;
        @(negedge clk);
        evt_pulse = '0;
    endtask

    initial begin
        repeat (60000) @(posedge clk);
        if (!done) begin
            errors++; checks++;
            $display("FAIL watchdog: actual=hung expected=finished");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

    initial begin
        logic [8:0] w;
        logic [5:0] pat;
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);

        // R1 reset state
        rd(1'b0, w); chk("R1 ctl reset", w[7:0], 8'h3F);
        rd(1'b1, w); chk("R1 flag reset", w[7:0], 8'h00);
        chk("R1 irq reset", irq_out, 0);
        chk("R10 mirror at reset", w[8], 0);

        // R6 live jack level
        jack_present = 1'b1;
        rd(1'b1, w); chk("R6 jack high", w[7:0], 8'h40);
        jack_present = 1'b0;
        rd(1'b1, w); chk("R6 jack low", w[7:0], 8'h00);

        // R2 control readback
        wr_ctl(8'hA5); rd(1'b0, w); chk("R2 ctl A5", w[7:0], 8'hA5);
        wr_ctl(8'h5A); rd(1'b0, w); chk("R2 ctl 5A", w[7:0], 8'h5A);
        wr_ctl(8'h3F);

        // R3 latch each source while fully masked
        pat = '0;
        for (int i = 0; i < 6; i++) begin
            fire(6'(1 << i));
            pat[i] = 1'b1;
            @(negedge clk);
            rd(1'b1, w);
            chk("R3 sticky latch", w[7:0], {2'b00, pat});
            chk("R7 masked quiet", irq_out, 0);
        end

        // R4 write-one-to-clear
        clr(8'h15); rd(1'b1, w); chk("R4 clear 15", w[7:0], 8'h2A);
        clr(8'h00); rd(1'b1, w); chk("R4 zero write", w[7:0], 8'h2A);
        clr(8'hC0); rd(1'b1, w); chk("R4 upper bits ignored", w[7:0], 8'h2A);
        clr(8'h3F); rd(1'b1, w); chk("R4 clear all", w[7:0], 8'h00);

        // R5 event beats simultaneous clear
        fire(6'h08);
        evt_pulse = 6'h0A; flag_wr_en = 1'b1; flag_wr_data = 8'h0A;
        @(negedge clk);
        evt_pulse = '0; flag_wr_en = 1'b0;
        rd(1'b1, w); chk("R5 event wins", w[7:0], 8'h0A);
        clr(8'h3F);

        // R7/R8 sweep over all masks, both level forms
        pat = 6'h2D;
        fire(pat);
        for (int m = 0; m < 64; m++) begin
            wr_ctl({2'b00, 6'(m)});
            rd(1'b0, w);
            chk("R8 high form", irq_out, int'(|(pat & ~6'(m))));
            chk("R10 mirror bit", w[8], irq_out);
        end
        for (int m = 0; m < 64; m++) begin
            wr_ctl({2'b01, 6'(m)});
            chk("R8 low form", irq_out, int'(!(|(pat & ~6'(m)))));
        end
        wr_ctl(8'h3F);
        clr(8'h3F);

        // R9 pulse form
        wr_ctl(8'h80);
        chk("R9 no pulse on form change", irq_out, 0);
        fire(6'h04);
        chk("R9 pulse high", irq_out, 1);
        @(negedge clk);
        chk("R9 pulse one cycle", irq_out, 0);
        fire(6'h04);
        chk("R9 already set", irq_out, 0);
        wr_ctl(8'h81);
        fire(6'h01);
        chk("R9 masked no pulse", irq_out, 0);
        rd(1'b1, w); chk("R3 latched while masked", w[7:0], 8'h05);
        wr_ctl(8'h80);
        chk("R9 unmask no pulse", irq_out, 0);
        wr_ctl(8'hC0);
        clr(8'h3F);
        fire(6'h20);
        rd(1'b0, w);
        chk("R9 form 11 pulse", irq_out, 1);
        chk("R10 pulse mirrored", w[8], 1);
        @(negedge clk);
        chk("R9 form 11 one cycle", irq_out, 0);

        done = 1'b1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

endmodule